// File: doc/BRIEF.md
# Element-Serial Vector Execution Unit

This block executes register-to-register vector instructions over a file of eight vector registers, each holding sixty-four 64-bit elements. An instruction names one destination and two source registers (source A and source B). Once accepted, the unit walks the element index from 0 to 63, fetching one pair of operands per cycle and pushing it through a three-stage integer pipeline. Each result is written back to the destination register at the moment it leaves the pipeline.

Beyond element-wise add, subtract and multiply, two instructions produce a single 64-bit scalar instead of a vector: a signed less-than compare that packs one bit per element into a mask, and an accumulate that sums every element of source A. The scalar appears on a dedicated result port with a one-cycle valid strobe. An element access port, usable while the unit is idle, lets the surrounding load/store logic place data in the register file and read it back; memory traffic itself is handled outside this block.

Top module: `vx_exec_unit`

## Requirements
- R1: After reset, `busy` is 0, `instr_ready` is 1 and `scalar_valid` is 0.
- R2: Opcode 0 writes A[i]+B[i], opcode 1 writes A[i]-B[i], opcode 2 writes the low 64 bits of A[i]*B[i] into destination element i, for all 64 elements, modulo 2^64; all of them are readable once `busy` has fallen.
- R3: An instruction is accepted only on a clock edge where `instr_valid` and `instr_ready` are both 1; `instr_ready` is 0 while `busy` is 1 and any instruction offered then has no effect.
- R4: `busy` rises on the edge after acceptance and stays 1 for exactly 67 cycles (64 elements plus 3 pipeline stages).
- R5: Opcode 3 yields a scalar whose bit i is 1 exactly when A[i] < B[i] as signed 64-bit numbers; no register is written.
- R6: Opcode 4 yields the sum of all 64 elements of source A modulo 2^64; no register is written.
- R7: For opcodes 3 and 4, `scalar_valid` is 1 for exactly one cycle, rising on the same edge on which `busy` falls; for other opcodes it stays 0.
- R8: The destination may equal either or both sources; every element result is computed from the source values held before the instruction.
- R9: An element write (`ew_valid`) is performed only while `busy` is 0 and is ignored while `busy` is 1; `er_data` shows element `er_idx` of register `er_reg` combinationally.
- R10: Opcodes 5 to 7 occupy the unit for the same 67 cycles but write no register and produce no scalar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_op | input | 3 | Opcode (0 add, 1 sub, 2 mul, 3 compare, 4 accumulate) |
| instr_dst | input | 3 | Destination register |
| instr_srca | input | 3 | Source A register |
| instr_srcb | input | 3 | Source B register |
| instr_ready | output | 1 | Unit can accept an instruction |
| busy | output | 1 | Instruction in progress |
| scalar_out | output | 64 | Last compare mask or accumulate sum |
| scalar_valid | output | 1 | One-cycle strobe for a new scalar |
| ew_valid | input | 1 | Element write request |
| ew_reg | input | 3 | Element write register |
| ew_idx | input | 6 | Element write index |
| ew_data | input | 64 | Element write data |
| er_reg | input | 3 | Element read register |
| er_idx | input | 6 | Element read index |
| er_data | output | 64 | Element read data |

## Verification
Counting from the accepting edge, element i is fetched on the next edge and written four edges after acceptance plus i, so the final element lands on the 67th edge, the same edge that drops `busy` and raises `scalar_valid` for one cycle. The bench drives and samples on falling edges, counts the high cycles of `busy` from the first falling edge after acceptance, expects the scalar strobe in the first sample with `busy` low and its absence one sample later, and reads the destination through the element port only after that point. Ignored inputs (instructions and element writes during `busy`) are judged by reading the registers they would have touched and by the length of the `busy` window.

// File: rtl/vx_pkg.sv
package vx_pkg;

    // Geometry of the register file and pipeline
    localparam int VX_W      = 64;
    localparam int VX_NREG   = 8;
    localparam int VX_NELEM  = 64;
    localparam int VX_STAGES = 3;
    localparam int VX_RW     = $clog2(VX_NREG);
    localparam int VX_IW     = $clog2(VX_NELEM);
    localparam int VX_AW     = VX_RW + VX_IW;
    localparam int VX_OCC    = VX_NELEM + VX_STAGES;

    // Opcodes
    localparam logic [2:0] OPC_ADD = 3'd0;
    localparam logic [2:0] OPC_SUB = 3'd1;
    localparam logic [2:0] OPC_MUL = 3'd2;
    localparam logic [2:0] OPC_CMP = 3'd3;
    localparam logic [2:0] OPC_ACC = 3'd4;

    typedef logic [VX_W-1:0] vx_elem_t;

    typedef struct packed {
        logic [2:0]       op;
        logic [VX_RW-1:0] dst;
        logic [VX_RW-1:0] srca;
        logic [VX_RW-1:0] srcb;
    } vx_instr_t;

    typedef struct packed {
        logic             vld;
        logic             last;
        logic [VX_IW-1:0] idx;
        vx_elem_t         a;
        vx_elem_t         b;
    } vx_opnd_t;

    typedef struct packed {
        logic             vld;
        logic             last;
        logic             wr;
        logic [VX_IW-1:0] idx;
        vx_elem_t         res;
    } vx_res_t;

    function automatic vx_elem_t vx_compute(input logic [2:0] op, input vx_elem_t a, input vx_elem_t b);
        vx_elem_t r;
        case (op)
            OPC_ADD: r = a + b;
            OPC_SUB: r = a - b;
            OPC_MUL: r = a * b;
            OPC_CMP: r = {{(VX_W-1){1'b0}}, ($signed(a) < $signed(b))};
            OPC_ACC: r = a;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic vx_writes(input logic [2:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB) || (op == OPC_MUL);
    endfunction

    function automatic logic vx_scalar_op(input logic [2:0] op);
        return (op == OPC_CMP) || (op == OPC_ACC);
    endfunction

endpackage

// File: rtl/vx_regfile.sv
module vx_regfile
    import vx_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic [VX_RW-1:0] wreg,
    input  logic [VX_IW-1:0] widx,
    input  vx_elem_t         wdata,
    input  logic [VX_RW-1:0] ra_reg,
    input  logic [VX_IW-1:0] ra_idx,
    output vx_elem_t         ra_data,
    input  logic [VX_RW-1:0] rb_reg,
    input  logic [VX_IW-1:0] rb_idx,
    output vx_elem_t         rb_data,
    input  logic [VX_RW-1:0] rx_reg,
    input  logic [VX_IW-1:0] rx_idx,
    output vx_elem_t         rx_data
);
    localparam int DEPTH = VX_NREG * VX_NELEM;

    vx_elem_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[{wreg, widx}] <= wdata;
        end
    end

    assign ra_data = mem[{ra_reg, ra_idx}];
    assign rb_data = mem[{rb_reg, rb_idx}];
    assign rx_data = mem[{rx_reg, rx_idx}];

endmodule

// File: rtl/vx_fu.sv
module vx_fu
    import vx_pkg::*;
#(
    parameter int PIPE_STAGES = VX_STAGES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] op,
    input  vx_opnd_t   in,
    output vx_res_t    out,
    output logic       active
);
    // Operand fetch is the first stage (in the top); the rest live here.
    localparam int LAT = PIPE_STAGES - 1;

    vx_res_t st [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LAT; k++) begin
                st[k] <= '0;
            end
        end else begin
            st[0].vld  <= in.vld;
            st[0].last <= in.last;
            st[0].wr   <= vx_writes(op);
            st[0].idx  <= in.idx;
            st[0].res  <= vx_compute(op, in.a, in.b);
            for (int k = 1; k < LAT; k++) begin
                st[k] <= st[k-1];
            end
        end
    end

    always_comb begin
        active = 1'b0;
        for (int k = 0; k < LAT; k++) begin
            active = active | st[k].vld;
        end
    end

    assign out = st[LAT-1];

endmodule

// File: rtl/vx_reduce.sv
module vx_reduce
    import vx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sc_en,
    input  logic     sel_cmp,
    input  vx_res_t  in,
    output vx_elem_t scalar_out,
    output logic     scalar_valid
);
    vx_elem_t run_q;
    vx_elem_t run_d;
    vx_elem_t base;

    always_comb begin
        base = (in.idx == '0) ? '0 : run_q;
        if (sel_cmp) begin
            run_d = base | (vx_elem_t'(in.res[0]) << in.idx);
        end else begin
            run_d = base + in.res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q        <= '0;
            scalar_out   <= '0;
            scalar_valid <= 1'b0;
        end else begin
            scalar_valid <= 1'b0;
            if (in.vld) begin
                run_q <= run_d;
                if (in.last && sc_en) begin
                    scalar_out   <= run_d;
                    scalar_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vx_exec_unit.sv
module vx_exec_unit
    import vx_pkg::*;
#(
    parameter int PIPE_STAGES = VX_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [2:0]       instr_op,
    input  logic [VX_RW-1:0] instr_dst,
    input  logic [VX_RW-1:0] instr_srca,
    input  logic [VX_RW-1:0] instr_srcb,
    output logic             instr_ready,
    output logic             busy,
    output logic [VX_W-1:0]  scalar_out,
    output logic             scalar_valid,
    input  logic             ew_valid,
    input  logic [VX_RW-1:0] ew_reg,
    input  logic [VX_IW-1:0] ew_idx,
    input  logic [VX_W-1:0]  ew_data,
    input  logic [VX_RW-1:0] er_reg,
    input  logic [VX_IW-1:0] er_idx,
    output logic [VX_W-1:0]  er_data
);
    localparam logic [VX_IW-1:0] LAST_IDX = VX_IW'(VX_NELEM - 1);

    vx_instr_t        cur_q;
    logic             issuing_q;
    logic [VX_IW-1:0] iidx_q;
    vx_opnd_t         opnd_q;
    vx_res_t          fu_out;
    logic             fu_active;
    vx_elem_t         rd_a;
    vx_elem_t         rd_b;
    logic             accept;

    logic             rf_we;
    logic [VX_RW-1:0] rf_wreg;
    logic [VX_IW-1:0] rf_widx;
    vx_elem_t         rf_wdata;

    assign busy        = issuing_q | opnd_q.vld | fu_active;
    assign instr_ready = ~busy;
    assign accept      = instr_valid & ~busy;

    // Sequencer and operand-fetch stage
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            issuing_q <= 1'b0;
            iidx_q    <= '0;
            opnd_q    <= '0;
        end else begin
            opnd_q.vld  <= issuing_q;
            opnd_q.last <= issuing_q && (iidx_q == LAST_IDX);
            opnd_q.idx  <= iidx_q;
            opnd_q.a    <= rd_a;
            opnd_q.b    <= rd_b;
            if (accept) begin
                cur_q     <= '{op: instr_op, dst: instr_dst, srca: instr_srca, srcb: instr_srcb};
                issuing_q <= 1'b1;
                iidx_q    <= '0;
            end else if (issuing_q) begin
                iidx_q <= iidx_q + 1'b1;
                if (iidx_q == LAST_IDX) begin
                    issuing_q <= 1'b0;
                end
            end
        end
    end

    // Write port arbitration: pipeline results only exist while busy
    always_comb begin
        if (fu_out.vld && fu_out.wr) begin
            rf_we    = 1'b1;
            rf_wreg  = cur_q.dst;
            rf_widx  = fu_out.idx;
            rf_wdata = fu_out.res;
        end else begin
            rf_we    = ew_valid & ~busy;
            rf_wreg  = ew_reg;
            rf_widx  = ew_idx;
            rf_wdata = ew_data;
        end
    end

    vx_regfile u_rf (
        .clk     (clk),
        .we      (rf_we),
        .wreg    (rf_wreg),
        .widx    (rf_widx),
        .wdata   (rf_wdata),
        .ra_reg  (cur_q.srca),
        .ra_idx  (iidx_q),
        .ra_data (rd_a),
        .rb_reg  (cur_q.srcb),
        .rb_idx  (iidx_q),
        .rb_data (rd_b),
        .rx_reg  (er_reg),
        .rx_idx  (er_idx),
        .rx_data (er_data)
    );

    vx_fu #(.PIPE_STAGES(PIPE_STAGES)) u_fu (
        .clk    (clk),
        .rst    (rst),
        .op     (cur_q.op),
        .in     (opnd_q),
        .out    (fu_out),
        .active (fu_active)
    );

    vx_reduce u_red (
        .clk          (clk),
        .rst          (rst),
        .sc_en        (vx_scalar_op(cur_q.op)),
        .sel_cmp      (cur_q.op == OPC_CMP),
        .in           (fu_out),
        .scalar_out   (scalar_out),
        .scalar_valid (scalar_valid)
    );

endmodule

// File: rtl/vx_exec_chk.sv
module vx_exec_chk
    import vx_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic instr_valid,
    input logic instr_ready,
    input logic busy,
    input logic scalar_valid
);
    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (instr_valid && instr_ready) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    // R3: an accepted instruction makes the unit busy on the next cycle
    p_accept_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_ready) |=> busy);

    // R4: occupancy window is exactly elements plus stages
    p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_cnt == 8'(VX_OCC)));

    // R7: the scalar strobe lasts one cycle
    p_scalar_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        scalar_valid |=> !scalar_valid);

    // R7: the scalar strobe coincides with the end of busy
    p_scalar_end_r7: assert property (@(posedge clk) disable iff (rst)
        scalar_valid |-> $fell(busy));

endmodule

bind vx_exec_unit vx_exec_chk u_vx_exec_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_valid  (instr_valid),
    .instr_ready  (instr_ready),
    .busy         (busy),
    .scalar_valid (scalar_valid)
);

// File: tb/test_vx_exec_unit.sv
module test_vx_exec_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [2:0]  instr_op = '0;
    logic [2:0]  instr_dst = '0;
    logic [2:0]  instr_srca = '0;
    logic [2:0]  instr_srcb = '0;
    logic        instr_ready;
    logic        busy;
    logic [63:0] scalar_out;
    logic        scalar_valid;
    logic        ew_valid = 1'b0;
    logic [2:0]  ew_reg = '0;
    logic [5:0]  ew_idx = '0;
    logic [63:0] ew_data = '0;
    logic [2:0]  er_reg = '0;
    logic [5:0]  er_idx = '0;
    logic [63:0] er_data;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    vx_exec_unit i_vx_exec_unit (
        .clk(clk), .rst(rst),
        .instr_valid(instr_valid), .instr_op(instr_op), .instr_dst(instr_dst),
        .instr_srca(instr_srca), .instr_srcb(instr_srcb),
        .instr_ready(instr_ready), .busy(busy),
        .scalar_out(scalar_out), .scalar_valid(scalar_valid),
        .ew_valid(ew_valid), .ew_reg(ew_reg), .ew_idx(ew_idx), .ew_data(ew_data),
        .er_reg(er_reg), .er_idx(er_idx), .er_data(er_data)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  d;
        logic [2:0]  a;
        logic [2:0]  b;
        logic [15:0] sa;
        logic [15:0] sb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 3'd2, 3'd0, 3'd1, 16'h1234, 16'h8001},
        '{3'd1, 3'd3, 3'd0, 3'd1, 16'h00FF, 16'hF00D},
        '{3'd2, 3'd4, 3'd0, 3'd1, 16'h7777, 16'h0C0C},
        '{3'd3, 3'd5, 3'd0, 3'd1, 16'hA5A5, 16'h5A5A},
        '{3'd4, 3'd5, 3'd0, 3'd0, 16'hBEEF, 16'hBEEF},
        '{3'd0, 3'd6, 3'd6, 3'd7, 16'h4321, 16'h9999},
        '{3'd2, 3'd0, 3'd0, 3'd0, 16'h0F0F, 16'h0F0F},
        '{3'd6, 3'd1, 3'd2, 3'd3, 16'h1111, 16'h2222}
    };

    logic [63:0] mdl [8][64];

    function automatic logic [63:0] pat(input logic [15:0] s, input int i);
        logic [63:0] x;
        x = ({48'd0, s} * 64'h9E3779B97F4A7C15) ^ (64'(i) * 64'hD1B54A32D192ED03);
        if (i % 7 == 0) x = 64'(i);
        return x;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [2:0] r, input logic [15:0] s);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            ew_valid = 1'b1; ew_reg = r; ew_idx = 6'(i); ew_data = pat(s, i);
            mdl[r][i] = pat(s, i);
        end
        @(negedge clk);
        ew_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] r, input int i, output logic [63:0] v);
        er_reg = r; er_idx = 6'(i);
        #1;
        v = er_data;
    endtask

    task automatic issue(input logic [2:0] op, input logic [2:0] d, input logic [2:0] a, input logic [2:0] b);
        @(negedge clk);
        instr_valid = 1'b1; instr_op = op; instr_dst = d; instr_srca = a; instr_srcb = b;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    // Compare a whole register against the model; one check per register
    task automatic chk_reg(input logic [2:0] r, input string req);
        logic [63:0] v;
        int bad = -1;
        logic [63:0] av = '0;
        for (int i = 0; i < 64; i++) begin
            rd(r, i, v);
            if (v !== mdl[r][i] && bad < 0) begin
                bad = i; av = v;
            end
        end
        if (bad >= 0) chk(1'b0, req, av, mdl[r][bad]);
        else          chk(1'b1, req, '0, '0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [63:0] ea [64];
        logic [63:0] es;
        logic [63:0] v;
        int n;
        logic sv_seen;
        string tag;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(instr_ready == 1'b1, "R1 instr_ready", 64'(instr_ready), 64'd1);
        chk(scalar_valid == 1'b0, "R1 scalar_valid", 64'(scalar_valid), 64'd0);

        for (int r = 0; r < 8; r++) fill(3'(r), 16'(100 + r));

        // Table walk
        for (int t = 0; t < NV; t++) begin
            fill(VEC[t].a, VEC[t].sa);
            if (VEC[t].b != VEC[t].a) fill(VEC[t].b, VEC[t].sb);
            es = '0;
            for (int i = 0; i < 64; i++) begin
                logic [63:0] x;
                logic [63:0] y;
                x = mdl[VEC[t].a][i];
                y = mdl[VEC[t].b][i];
                case (VEC[t].op)
                    3'd0: ea[i] = x + y;
                    3'd1: ea[i] = x - y;
                    3'd2: ea[i] = x * y;
                    default: ea[i] = mdl[VEC[t].d][i];
                endcase
                if (VEC[t].op == 3'd3 && $signed(x) < $signed(y)) es[i] = 1'b1;
                if (VEC[t].op == 3'd4) es = es + x;
            end
            issue(VEC[t].op, VEC[t].d, VEC[t].a, VEC[t].b);
            n = 0; sv_seen = 1'b0;
            while (busy === 1'b1 && n < 200) begin
                if (scalar_valid) sv_seen = 1'b1;
                n++;
                @(negedge clk);
            end
            chk(n == 67, "R4 busy length", 64'(n), 64'd67);
            if (VEC[t].op == 3'd3 || VEC[t].op == 3'd4) begin
                tag = (VEC[t].op == 3'd3) ? "R5 compare mask" : "R6 accumulate sum";
                chk(scalar_valid === 1'b1 && !sv_seen, "R7 scalar strobe at busy fall", 64'(scalar_valid), 64'd1);
                chk(scalar_out === es, tag, scalar_out, es);
                @(negedge clk);
                chk(scalar_valid === 1'b0, "R7 strobe one cycle", 64'(scalar_valid), 64'd0);
            end else begin
                chk(scalar_valid === 1'b0 && !sv_seen, "R7 no strobe for vector op", 64'(scalar_valid), 64'd0);
            end
            for (int i = 0; i < 64; i++) mdl[VEC[t].d][i] = ea[i];
            if (VEC[t].op > 3'd4)                                      tag = "R10 no write";
            else if (VEC[t].d == VEC[t].a || VEC[t].d == VEC[t].b)   tag = "R8 dst aliases src";
            else if (VEC[t].op >= 3'd3)                                tag = "R5 R6 dst untouched";
            else                                                       tag = "R2 elementwise result";
            chk_reg(VEC[t].d, tag);
        end

        // R3 and R9: instruction and element write while busy are ignored
        for (int i = 0; i < 64; i++) ea[i] = mdl[0][i] + mdl[1][i];
        issue(3'd0, 3'd2, 3'd0, 3'd1);
        n = 0;
        for (int k = 0; k < 10; k++) begin
            if (k == 0) chk(instr_ready === 1'b0, "R3 not ready while busy", 64'(instr_ready), 64'd0);
            instr_valid = 1'b1; instr_op = 3'd1; instr_dst = 3'd1; instr_srca = 3'd0; instr_srcb = 3'd0;
            ew_valid = (k == 0); ew_reg = 3'd7; ew_idx = 6'd0; ew_data = 64'hDEAD_BEEF_0000_0001;
            n++;
            @(negedge clk);
        end
        instr_valid = 1'b0; ew_valid = 1'b0;
        while (busy === 1'b1 && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk(n == 67, "R3 R4 busy not extended by ignored instr", 64'(n), 64'd67);
        for (int i = 0; i < 64; i++) mdl[2][i] = ea[i];
        chk_reg(3'd1, "R3 ignored instruction left dst intact");
        rd(3'd7, 0, v);
        chk(v === mdl[7][0], "R9 write while busy ignored", v, mdl[7][0]);
        chk_reg(3'd2, "R2 accepted add result");

        // R9: write while idle takes effect
        @(negedge clk);
        ew_valid = 1'b1; ew_reg = 3'd7; ew_idx = 6'd63; ew_data = 64'h0123_4567_89AB_CDEF;
        @(negedge clk);
        ew_valid = 1'b0;
        rd(3'd7, 63, v);
        chk(v === 64'h0123_4567_89AB_CDEF, "R9 idle write visible", v, 64'h0123_4567_89AB_CDEF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule